// File: doc/BRIEF.md
# GF(2^11) Polynomial Root Scanner

This block finds every root of a polynomial over GF(2^11) by brute force. It evaluates the polynomial at each of the 2048 field elements in turn and reports one result bit per element: the bit is 1 when the polynomial vanishes there. A decoder uses it after it has formed an error locator polynomial, and the result stream is the error position vector.

Software or a preceding stage writes up to 51 coefficients of 11 bits each into an internal coefficient bank through an address/data port. It then pulses `start` together with the polynomial degree. The block derives each field element on the fly from a running index and keeps no table of elements. It applies Horner's rule with one field multiply and one XOR per cycle. For each element it emits a `res_valid` strobe carrying the result bit and the element index, and it raises `done` for one cycle after the last element.

Top module: `gf_root_scanner`

## Requirements
- R1: All products are formed in GF(2^11) with the reduction polynomial x^11 + x^2 + 1, and element i is the 11-bit value i read as a polynomial-basis vector (bit k is the coefficient of x^k), including element 0.
- R2: One run reports exactly 2048 results on `res_valid`, with `res_idx` running 0, 1, ..., 2047 in ascending order.
- R3: `start` is accepted only while `busy` is low; `busy` is high from the first edge after acceptance, and a `start` seen while busy has no effect on the run.
- R4: `res_bit` is 1 exactly when c0 + x(c1 + x(c2 + ... + x·cd)) equals zero at element `res_idx`. An all-zero polynomial gives all ones, and a nonzero constant gives all zeros.
- R5: `done` is high for exactly one cycle, in the same cycle as the result for element 2047, and `busy` is low in that cycle.
- R6: With effective degree d, the result for element i appears (i+1)(d+1) cycles after the edge that accepts `start`.
- R7: A `deg` value above 50 is treated as 50.
- R8: Coefficient writes made while `busy` is high are ignored. The results of that run and of later runs use the coefficients held at start.
- R9: After reset, `busy`, `done` and `res_valid` are low and every coefficient is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cf_wr | input | 1 | Coefficient write enable |
| cf_addr | input | 6 | Coefficient index (0 = constant term) |
| cf_data | input | 11 | Coefficient value |
| deg | input | 6 | Polynomial degree, sampled when start is accepted |
| start | input | 1 | Start strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| res_valid | output | 1 | Result bit strobe |
| res_bit | output | 1 | 1 when the polynomial is zero at the element |
| res_idx | output | 11 | Element index of the current result |

## Verification
The bench goes after element 0, where the polynomial collapses to its constant term; an engine that mishandles zero or skips the first element would misreport it. It checks an all-zero polynomial and a constant polynomial, which show whether the zero test is inverted. It also uses products of chosen linear factors up to degree 50 with an oversized degree input; a wrong reduction polynomial, a dropped top coefficient or a missing clamp would scatter the expected root bits. Mid-run pokes of `start` and of a coefficient write would restart the index sequence or corrupt later results if they were not blocked, and the per-element cycle timing exposes an off-by-one in the step counter.

// File: rtl/gf_scan_pkg.sv
package gf_scan_pkg;
  localparam int FIELD_M        = 11;
  localparam int POLY_MAX_DEG   = 50;
  // x^11 + x^2 + 1 without the leading term
  localparam logic [FIELD_M-1:0] FIELD_TAIL = 11'h005;
  typedef logic [FIELD_M-1:0] gf_elem_t;
endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int              M    = gf_scan_pkg::FIELD_M,
  parameter logic [M-1:0]    TAIL = gf_scan_pkg::FIELD_TAIL
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  // MSB-first shift-and-add with interleaved reduction
  logic [M-1:0] part [M+1];
  assign part[0] = '0;

  genvar i;
  generate
    for (i = 0; i < M; i++) begin : g_stage
      logic [M-1:0] shifted;
      assign shifted     = {part[i][M-2:0], 1'b0} ^ (part[i][M-1] ? TAIL : '0);
      assign part[i+1]   = shifted ^ (b[M-1-i] ? a : '0);
    end
  endgenerate

  assign p = part[M];
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int M     = gf_scan_pkg::FIELD_M,
  parameter int NCOEF = gf_scan_pkg::POLY_MAX_DEG + 1,
  parameter int AW    = $clog2(NCOEF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [M-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [M-1:0]  rd_data,
  output logic [M-1:0]  c0
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NCOEF - 1);

  logic [M-1:0] regs [NCOEF];

  genvar k;
  generate
    for (k = 0; k < NCOEF; k++) begin : g_reg
      logic sel;
      assign sel = wr_en && (wr_addr == AW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[k] <= '0;
        else if (sel) regs[k] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_idx <= LAST_IDX) rd_data = regs[rd_idx];
  end

  assign c0 = regs[0];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int EW      = gf_scan_pkg::FIELD_M,
  parameter int MAX_DEG = gf_scan_pkg::POLY_MAX_DEG,
  parameter int DW      = $clog2(MAX_DEG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] deg_in,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          last_step,
  output logic [EW-1:0] elem,
  output logic [DW-1:0] step
);
  localparam logic [DW-1:0] DEG_CAP  = DW'(MAX_DEG);
  localparam logic [EW-1:0] ELEM_TOP = '1;

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [EW-1:0] elem_q, elem_d;
  logic [DW-1:0] step_q, step_d;
  logic [DW-1:0] deg_q,  deg_d;
  logic [DW-1:0] deg_clamped;
  logic          run_en;

  assign accept      = start && !busy_q;
  assign deg_clamped = (deg_in > DEG_CAP) ? DEG_CAP : deg_in;
  assign last_step   = busy_q && (step_q == '0);
  assign run_en      = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    elem_d = elem_q;
    step_d = step_q;
    deg_d  = deg_q;
    if (accept) begin
      busy_d = 1'b1;
      elem_d = '0;
      step_d = deg_clamped;
      deg_d  = deg_clamped;
    end else if (busy_q) begin
      if (step_q == '0) begin
        step_d = deg_q;
        elem_d = elem_q + 1'b1;
        if (elem_q == ELEM_TOP) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        step_d = step_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      elem_q <= '0;
      step_q <= '0;
      deg_q  <= '0;
    end else begin
      done_q <= done_d;
      if (run_en) begin
        busy_q <= busy_d;
        elem_q <= elem_d;
        step_q <= step_d;
        deg_q  <= deg_d;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign elem = elem_q;
  assign step = step_q;
endmodule

// File: rtl/gf_root_scanner.sv
module gf_root_scanner #(
  parameter int              M       = gf_scan_pkg::FIELD_M,
  parameter logic [M-1:0]    TAIL    = gf_scan_pkg::FIELD_TAIL,
  parameter int              MAX_DEG = gf_scan_pkg::POLY_MAX_DEG,
  parameter int              NCOEF   = MAX_DEG + 1,
  parameter int              AW      = $clog2(NCOEF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cf_wr,
  input  logic [AW-1:0] cf_addr,
  input  logic [M-1:0]  cf_data,
  input  logic [AW-1:0] deg,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          res_valid,
  output logic          res_bit,
  output logic [M-1:0]  res_idx
);
  logic          accept;
  logic          last_step;
  logic [M-1:0]  elem;
  logic [AW-1:0] step;
  logic [M-1:0]  coef_rd;
  logic [M-1:0]  coef0_w;
  logic [M-1:0]  acc_q, acc_d, acc_next, prod;
  logic          acc_en;
  logic          valid_q;
  logic          bit_q;
  logic [M-1:0]  idx_q;

  scan_ctrl #(.EW(M), .MAX_DEG(MAX_DEG), .DW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .deg_in(deg),
    .accept(accept), .busy(busy), .done(done), .last_step(last_step),
    .elem(elem), .step(step)
  );

  coef_bank #(.M(M), .NCOEF(NCOEF), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cf_wr && !busy), .wr_addr(cf_addr),
    .wr_data(cf_data), .rd_idx(step), .rd_data(coef_rd), .c0(coef0_w)
  );

  gf_mul #(.M(M), .TAIL(TAIL)) u_mul (.a(acc_q), .b(elem), .p(prod));

  // Horner step: acc <- acc*x + c[step]
  assign acc_d  = prod ^ coef_rd;
  assign acc_en = accept || busy;

  always_comb begin
    acc_next = acc_d;
    if (accept || last_step) acc_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= last_step;
      if (last_step) begin
        bit_q <= (acc_d == '0);
        idx_q <= elem;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_bit   = bit_q;
  assign res_idx   = idx_q;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int M = gf_scan_pkg::FIELD_M
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         res_valid,
  input logic         res_bit,
  input logic [M-1:0] res_idx,
  input logic [M-1:0] coef0
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && res_valid && (res_idx == '1)));

  p_valid_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  // element 0 reduces the polynomial to its constant term
  p_elem_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_idx == '0) |-> (res_bit == (coef0 == '0)));
endmodule

bind gf_root_scanner scan_checker #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .res_bit(res_bit), .res_idx(res_idx), .coef0(coef0_w)
);

// File: tb/sim_gf_root_scanner.sv
module sim_gf_root_scanner;
  localparam int CLK_P = 10;
  localparam int NEL   = 2048;

  logic        clk;
  logic        rst_n;
  logic        cf_wr;
  logic [5:0]  cf_addr;
  logic [10:0] cf_data;
  logic [5:0]  deg;
  logic        start;
  logic        busy, done, res_valid, res_bit;
  logic [10:0] res_idx;

  int n_chk;
  int n_bad;
  logic [10:0] mdl [51];
  bit          exp_vec [NEL];

  gf_root_scanner u0 (
    .clk(clk), .rst_n(rst_n), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_data(cf_data),
    .deg(deg), .start(start), .busy(busy), .done(done),
    .res_valid(res_valid), .res_bit(res_bit), .res_idx(res_idx)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // full product, then long division by x^11 + x^2 + 1
  function automatic logic [10:0] fmul(input logic [10:0] a, input logic [10:0] b);
    logic [20:0] pr;
    pr = '0;
    for (int i = 0; i < 11; i++) if (b[i]) pr ^= (21'(a) << i);
    for (int k = 20; k >= 11; k--) if (pr[k]) pr ^= (21'h805 << (k - 11));
    return pr[10:0];
  endfunction

  function automatic logic [10:0] peval(input int d, input logic [10:0] x);
    logic [10:0] acc;
    acc = '0;
    for (int j = d; j >= 0; j--) acc = fmul(acc, x) ^ mdl[j];
    return acc;
  endfunction

  task automatic note(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_coef(input int a, input logic [10:0] v);
    @(negedge clk);
    cf_wr = 1'b1; cf_addr = 6'(a); cf_data = v;
    @(negedge clk);
    cf_wr = 1'b0;
  endtask

  task automatic load_model;
    for (int j = 0; j < 51; j++) put_coef(j, mdl[j]);
  endtask

  task automatic model_roots(input int cnt, input int base);
    for (int j = 0; j < 51; j++) mdl[j] = '0;
    mdl[0] = 11'd1;
    for (int r = 0; r < cnt; r++) begin
      logic [10:0] root;
      root = 11'((base + r * 37) % NEL);
      for (int j = 50; j >= 1; j--) mdl[j] = mdl[j-1] ^ fmul(mdl[j], root);
      mdl[0] = fmul(mdl[0], root);
    end
  endtask

  task automatic run_scan(input int d_in, input bit poke);
    int d, cnt, nxt, limit;
    bit fin;
    d = (d_in > 50) ? 50 : d_in;
    for (int i = 0; i < NEL; i++) exp_vec[i] = (peval(d, 11'(i)) == '0);
    limit = NEL * (d + 1) + 20;
    @(negedge clk);
    deg = 6'(d_in); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; nxt = 0; fin = 1'b0;
    note(busy == 1'b1, "R3", "busy after start", int'(busy), 1);
    while (!fin) begin
      if (res_valid) begin
        note(int'(res_idx) == nxt, "R2", "index order", int'(res_idx), nxt);
        note(cnt == (nxt + 1) * (d + 1), "R6", "result cycle", cnt, (nxt + 1) * (d + 1));
        note(res_bit == exp_vec[res_idx], "R4", "root bit (R1 arithmetic)", int'(res_bit), int'(exp_vec[res_idx]));
        nxt++;
      end
      if (done) begin
        note(cnt == NEL * (d + 1), "R6", "done cycle", cnt, NEL * (d + 1));
        note(nxt == NEL, "R2", "result count", nxt, NEL);
        note(busy == 1'b0, "R5", "busy at done", int'(busy), 0);
        fin = 1'b1;
      end else if (cnt > limit) begin
        note(1'b0, "R5", "run never finished", cnt, limit);
        fin = 1'b1;
      end
      if (poke && cnt == 3) begin
        start = 1'b1; cf_wr = 1'b1; cf_addr = 6'd0; cf_data = ~mdl[0];
      end
      if (poke && cnt == 4) begin
        start = 1'b0; cf_wr = 1'b0;
      end
      if (!fin) begin
        @(negedge clk);
        cnt++;
      end
    end
    @(negedge clk);
    note(done == 1'b0, "R5", "done one cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cf_wr = 1'b0; cf_addr = '0; cf_data = '0; deg = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    note(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R9", "reset outputs",
         int'({busy, done, res_valid}), 0);
    rst_n = 1'b1;

    // R9: reset coefficients are zero, so every element is a root (R4)
    for (int j = 0; j < 51; j++) mdl[j] = '0;
    run_scan(2, 1'b0);

    // R4: nonzero constant never vanishes
    mdl[0] = 11'h3A1;
    load_model();
    run_scan(0, 1'b0);

    // R1/R4: three chosen roots, including element 0
    model_roots(3, 0);
    load_model();
    run_scan(3, 1'b0);

    // R3/R8: random polynomial, start and a write poked mid-run
    for (int j = 0; j < 51; j++) mdl[j] = 11'($urandom);
    mdl[7] = 11'($urandom) | 11'd1;
    load_model();
    run_scan(7, 1'b1);
    // R8: the blocked write must not have reached the bank
    run_scan(7, 1'b0);

    // R4: random low-degree polynomial with roots at random spots
    model_roots(5, int'($urandom % NEL));
    load_model();
    run_scan(5, 1'b0);

    // R7: degree input 63 clamps to 50; 50 distinct roots
    model_roots(50, int'($urandom % NEL));
    load_model();
    run_scan(63, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule